// File: doc/BRIEF.md
# Lock Contention Spin Classifier

This block watches the atomic-operation events that one CPU retires and measures how long that CPU is held up on each contended lock. An atomic attempt that leaves the lock word unchanged is a failed acquire. The first such attempt on an address opens a contention episode for that address. The episode closes when the same CPU next acquires the same address with an atomic that changes the lock word. While an episode is open, the block counts retired instructions, one per cycle in which the retire strobe is high.

When an episode closes, the block reports the address, the length and a class bit. A short episode is a spin, in which the thread kept busy-waiting. A long episode, longer than a fixed instruction threshold, is a wait, which is taken to mean the thread was switched out. The block keeps a saturating total of the instructions spent spinning. It also keeps a count of wait episodes and a count of failed attempts that were dropped because no tracking slot was free. All three counters can be read at any time.

Top module: `lock_spin_classifier`

## Requirements
- R1: A failed attempt (`atomValid`=1, `atomSuccess`=0) on an address with no open episode opens an episode in a free slot, and the length count starts at zero.
- R2: A further failed attempt on an address whose episode is already open neither restarts nor alters that episode's count.
- R3: A successful attempt (`atomSuccess`=1) on an address with an open episode closes it. In the next cycle `epValid` is high for exactly one cycle, with `epAddr` equal to that address.
- R4: `epLen` equals the number of cycles with `instRet`=1 strictly between the opening cycle and the closing cycle.
- R5: When the length exceeds WAIT_LIMIT (default 4096), the episode is reported with `epWait`=1 and `epLen` held at WAIT_LIMIT+1. A length of exactly WAIT_LIMIT reports `epWait`=0.
- R6: `spinTotal` grows by `epLen` for each spin episode only and saturates at its all-ones value. A wait episode leaves it unchanged.
- R7: `waitCount` grows by one for each wait episode and saturates.
- R8: Four episodes can be open at once. A failed attempt on a new address while all four slots are busy opens nothing and adds one to `ovfCount`, which saturates.
- R9: A successful attempt on an address with no open episode produces no report and changes no counter.
- R10: After reset, no episode is open, `epValid` is low and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instRet | input | 1 | One instruction retired this cycle |
| atomValid | input | 1 | An atomic attempt is presented this cycle |
| atomSuccess | input | 1 | The attempt changed the lock word (acquired) |
| atomAddr | input | ADDR_W | Lock address of the attempt |
| epValid | output | 1 | One-cycle pulse: an episode finished |
| epAddr | output | ADDR_W | Address of the finished episode |
| epLen | output | clog2(WAIT_LIMIT+2) | Episode length in retired instructions, capped |
| epWait | output | 1 | 1 = wait episode, 0 = spin episode |
| spinTotal | output | SPIN_W | Saturating sum of spin episode lengths |
| waitCount | output | CNT_W | Saturating count of wait episodes |
| ovfCount | output | CNT_W | Saturating count of attempts dropped for lack of a slot |

## Verification
A slot left busy, matched to the wrong address, or given a counter that restarts shows up at the report port. When the episode closes, it gives a missing or unexpected pulse, a wrong address or a wrong length, one cycle after the closing attempt. A mistake in the threshold compare or the cap shows on `epWait` and `epLen` for episodes of exactly WAIT_LIMIT, WAIT_LIMIT+1 and well beyond. It also shows on the spin total and wait count in that same cycle. A slot-allocation error shows either as an overflow count rising while a slot is free, or as lost reports when five addresses compete.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int SLOT_CNT   = 4;
  localparam int SLOT_IDX_W = $clog2(SLOT_CNT);

  typedef struct packed {
    logic                  allocEn;
    logic [SLOT_IDX_W-1:0] allocIdx;
    logic                  closeEn;
    logic [SLOT_IDX_W-1:0] closeIdx;
    logic                  ovfBump;
  } lcsStrobe_t;
endpackage

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             atomValid,
  input  logic                             atomSuccess,
  input  logic [ADDR_W-1:0]                atomAddr,
  input  logic [SLOT_CNT-1:0]              slotBusy,
  input  logic [SLOT_CNT-1:0][ADDR_W-1:0]  slotAddr,
  output lcsStrobe_t                       strobe
);

  logic [SLOT_CNT-1:0]   hitVec;
  logic                  anyHit;
  logic                  anyFree;
  logic [SLOT_IDX_W-1:0] hitIdx;
  logic [SLOT_IDX_W-1:0] freeIdx;

  // per-slot address match, only on slots holding an open episode
  for (genvar g = 0; g < SLOT_CNT; g++) begin : gMatch
    assign hitVec[g] = slotBusy[g] && (slotAddr[g] == atomAddr);
  end

  always_comb begin
    anyHit  = |hitVec;
    anyFree = ~&slotBusy;
    hitIdx  = '0;
    freeIdx = '0;
    // walk downward so the lowest index wins
    for (int i = SLOT_CNT - 1; i >= 0; i--) begin
      if (hitVec[i])    hitIdx  = SLOT_IDX_W'(i);
      if (!slotBusy[i]) freeIdx = SLOT_IDX_W'(i);
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.allocIdx = freeIdx;
    strobe.closeIdx = hitIdx;
    if (atomValid) begin
      if (atomSuccess) begin
        strobe.closeEn = anyHit;
      end else if (!anyHit) begin
        if (anyFree) strobe.allocEn = 1'b1;
        else         strobe.ovfBump = 1'b1;
      end
    end
  end

  // R8: overflow only when every slot holds an open episode
  p_ovf_only_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ovfBump |-> (&slotBusy));

  // R1: allocation always targets a free slot
  p_alloc_free_slot_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocEn |-> !slotBusy[strobe.allocIdx]);

  // R3: a close always targets an occupied slot of the same address
  p_close_busy_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.closeEn |-> (slotBusy[strobe.closeIdx] && slotAddr[strobe.closeIdx] == atomAddr));

  // R2: no two slots ever track the same address
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    atomValid |-> $onehot0(hitVec));

endmodule

// File: rtl/lcs_datapath.sv
module lcs_datapath
  import lcs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAIT_LIMIT = 4096,
  parameter int SPIN_W     = 32,
  parameter int CNT_W      = 16,
  localparam int LEN_W     = $clog2(WAIT_LIMIT + 2)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             instRet,
  input  logic [ADDR_W-1:0]                atomAddr,
  input  lcsStrobe_t                       strobe,
  output logic [SLOT_CNT-1:0]              slotBusy,
  output logic [SLOT_CNT-1:0][ADDR_W-1:0]  slotAddr,
  output logic                             epValid,
  output logic [ADDR_W-1:0]                epAddr,
  output logic [LEN_W-1:0]                 epLen,
  output logic                             epWait,
  output logic [SPIN_W-1:0]                spinTotal,
  output logic [CNT_W-1:0]                 waitCount,
  output logic [CNT_W-1:0]                 ovfCount
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(WAIT_LIMIT + 1);
  localparam logic [LEN_W-1:0] LEN_THR = LEN_W'(WAIT_LIMIT);

  logic [SLOT_CNT-1:0][LEN_W-1:0] slotCnt;

  for (genvar g = 0; g < SLOT_CNT; g++) begin : gSlot
    logic allocHere, closeHere;
    assign allocHere = strobe.allocEn && (strobe.allocIdx == SLOT_IDX_W'(g));
    assign closeHere = strobe.closeEn && (strobe.closeIdx == SLOT_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotBusy[g] <= 1'b0;
        slotAddr[g] <= '0;
        slotCnt[g]  <= '0;
      end else if (allocHere) begin
        slotBusy[g] <= 1'b1;
        slotAddr[g] <= atomAddr;
        slotCnt[g]  <= '0;
      end else if (closeHere) begin
        slotBusy[g] <= 1'b0;
        slotCnt[g]  <= '0;
      end else if (slotBusy[g] && instRet && slotCnt[g] != LEN_CAP) begin
        slotCnt[g]  <= slotCnt[g] + 1'b1;
      end
    end

    // R5: an open count never passes the cap
    p_cnt_capped_r5: assert property (@(posedge clk) disable iff (!rstN)
      slotCnt[g] <= LEN_CAP);
  end

  logic [LEN_W-1:0] closeLen;
  logic             closeIsWait;
  logic [SPIN_W:0]  spinSum;

  always_comb begin
    closeLen    = slotCnt[strobe.closeIdx];
    closeIsWait = closeLen > LEN_THR;
    spinSum     = {1'b0, spinTotal} + (SPIN_W + 1)'(closeLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epValid   <= 1'b0;
      epAddr    <= '0;
      epLen     <= '0;
      epWait    <= 1'b0;
      spinTotal <= '0;
      waitCount <= '0;
      ovfCount  <= '0;
    end else begin
      epValid <= strobe.closeEn;
      if (strobe.closeEn) begin
        epAddr <= slotAddr[strobe.closeIdx];
        epLen  <= closeLen;
        epWait <= closeIsWait;
        if (closeIsWait) begin
          if (waitCount != '1) waitCount <= waitCount + 1'b1;
        end else begin
          spinTotal <= spinSum[SPIN_W] ? '1 : spinSum[SPIN_W-1:0];
        end
      end
      if (strobe.ovfBump && ovfCount != '1) ovfCount <= ovfCount + 1'b1;
    end
  end

  // R5: class bit agrees with the reported length
  p_wait_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    epValid |-> (epWait == (epLen > LEN_THR)));

  // R6: the spin total never falls
  p_spin_monotone_r6: assert property (@(posedge clk) disable iff (!rstN)
    spinTotal >= $past(spinTotal));

  // R6: a wait report leaves the spin total untouched
  p_wait_no_spin_r6: assert property (@(posedge clk) disable iff (!rstN)
    (epValid && epWait) |-> (spinTotal == $past(spinTotal)));

  // R7: wait count steps by at most one
  p_wait_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (waitCount == $past(waitCount)) || (waitCount == $past(waitCount) + 1'b1));

  // R8: overflow count steps by at most one
  p_ovf_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCount == $past(ovfCount)) || (ovfCount == $past(ovfCount) + 1'b1));

endmodule

// File: rtl/lock_spin_classifier.sv
module lock_spin_classifier
  import lcs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAIT_LIMIT = 4096,
  parameter int SPIN_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  instRet,
  input  logic                                  atomValid,
  input  logic                                  atomSuccess,
  input  logic [ADDR_W-1:0]                     atomAddr,
  output logic                                  epValid,
  output logic [ADDR_W-1:0]                     epAddr,
  output logic [$clog2(WAIT_LIMIT + 2)-1:0]     epLen,
  output logic                                  epWait,
  output logic [SPIN_W-1:0]                     spinTotal,
  output logic [CNT_W-1:0]                      waitCount,
  output logic [CNT_W-1:0]                      ovfCount
);

  lcsStrobe_t                      strobe;
  logic [SLOT_CNT-1:0]             slotBusy;
  logic [SLOT_CNT-1:0][ADDR_W-1:0] slotAddr;

  lcs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .atomValid  (atomValid),
    .atomSuccess(atomSuccess),
    .atomAddr   (atomAddr),
    .slotBusy   (slotBusy),
    .slotAddr   (slotAddr),
    .strobe     (strobe)
  );

  lcs_datapath #(
    .ADDR_W    (ADDR_W),
    .WAIT_LIMIT(WAIT_LIMIT),
    .SPIN_W    (SPIN_W),
    .CNT_W     (CNT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .instRet  (instRet),
    .atomAddr (atomAddr),
    .strobe   (strobe),
    .slotBusy (slotBusy),
    .slotAddr (slotAddr),
    .epValid  (epValid),
    .epAddr   (epAddr),
    .epLen    (epLen),
    .epWait   (epWait),
    .spinTotal(spinTotal),
    .waitCount(waitCount),
    .ovfCount (ovfCount)
  );

  // R3: a report is always caused by a successful attempt one cycle earlier
  p_report_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    epValid |-> $past(atomValid && atomSuccess));

  // R10: nothing is reported straight out of reset
  p_quiet_after_reset_r10: assert property (@(posedge clk)
    !$past(rstN) |-> !epValid);

endmodule

// File: tb/sim_lock_spin_classifier.sv
module sim_lock_spin_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WAIT_LIMIT = 4096;
  localparam int LEN_W      = $clog2(WAIT_LIMIT + 2);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instRet = 1'b0;
  logic              atomValid = 1'b0;
  logic              atomSuccess = 1'b0;
  logic [ADDR_W-1:0] atomAddr = '0;
  logic              epValid;
  logic [ADDR_W-1:0] epAddr;
  logic [LEN_W-1:0]  epLen;
  logic              epWait;
  logic [31:0]       spinTotal;
  logic [15:0]       waitCount;
  logic [15:0]       ovfCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_spin_classifier u0 (
    .clk(clk), .rstN(rstN), .instRet(instRet), .atomValid(atomValid),
    .atomSuccess(atomSuccess), .atomAddr(atomAddr), .epValid(epValid),
    .epAddr(epAddr), .epLen(epLen), .epWait(epWait), .spinTotal(spinTotal),
    .waitCount(waitCount), .ovfCount(ovfCount)
  );

  typedef struct { logic [ADDR_W-1:0] addr; int len; bit wt; string req; } expItem_t;
  expItem_t expQ[$];

  int     nChecks = 0;
  int     nFails  = 0;
  longint modelSpin = 0;
  int     modelWait = 0;
  int     modelOvf  = 0;
  bit     finished  = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // one atomic attempt, one cycle, no instruction retired in it
  task automatic attempt(logic [ADDR_W-1:0] a, bit ok);
    atomValid = 1'b1; atomSuccess = ok; atomAddr = a; instRet = 1'b0;
    @(negedge clk);
    atomValid = 1'b0; atomSuccess = 1'b0;
  endtask

  task automatic idle(int n, bit r);
    instRet = r;
    repeat (n) @(negedge clk);
    instRet = 1'b0;
  endtask

  // scoreboard push: expected report and model totals
  task automatic expectEp(logic [ADDR_W-1:0] a, int rawLen, string req);
    expItem_t it;
    it.addr = a;
    it.req  = req;
    if (rawLen > WAIT_LIMIT) begin
      it.len = WAIT_LIMIT + 1; it.wt = 1; modelWait++;
    end else begin
      it.len = rawLen; it.wt = 0; modelSpin += rawLen;
    end
    expQ.push_back(it);
  endtask

  // monitor: pops the scoreboard on every report
  always @(negedge clk) begin
    if (rstN && epValid) begin
      if (expQ.size() == 0) begin
        check(0, "R9", "unexpected report addr", longint'(epAddr), 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(epAddr == it.addr, it.req, "report addr", longint'(epAddr), longint'(it.addr));
        check(int'(epLen) == it.len, it.req, "report length", longint'(epLen), it.len);
        check(epWait == it.wt, it.req, "report class", longint'(epWait), it.wt);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(epValid == 0, "R10", "epValid after reset", epValid, 0);
    check(spinTotal == 0, "R10", "spinTotal after reset", spinTotal, 0);
    check(waitCount == 0, "R10", "waitCount after reset", waitCount, 0);
    check(ovfCount == 0, "R10", "ovfCount after reset", ovfCount, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R3 R4: plain episode of 10 instructions
    attempt(32'hA000_0010, 0);
    idle(10, 1);
    expectEp(32'hA000_0010, 10, "R4");
    attempt(32'hA000_0010, 1);
    check(spinTotal == modelSpin, "R6", "spinTotal after spin", spinTotal, modelSpin);

    // R2: repeated failure extends, does not restart
    attempt(32'hB000_0020, 0);
    idle(5, 1);
    attempt(32'hB000_0020, 0);
    idle(7, 1);
    expectEp(32'hB000_0020, 12, "R2");
    attempt(32'hB000_0020, 1);

    // R4: cycles without retirement do not count
    attempt(32'hC000_0030, 0);
    idle(3, 0);
    idle(4, 1);
    idle(2, 0);
    expectEp(32'hC000_0030, 4, "R4");
    attempt(32'hC000_0030, 1);

    // R9: success without open episode does nothing
    attempt(32'hD000_0040, 1);
    idle(2, 0);
    check(spinTotal == modelSpin, "R9", "spinTotal unchanged", spinTotal, modelSpin);
    check(waitCount == 0, "R9", "waitCount unchanged", waitCount, 0);

    // R8: four slots full, fifth address overflows
    attempt(32'h100, 0);
    attempt(32'h200, 0);
    attempt(32'h300, 0);
    attempt(32'h400, 0);
    attempt(32'h500, 0);
    modelOvf++;
    check(ovfCount == modelOvf, "R8", "ovfCount after fifth address", ovfCount, modelOvf);
    attempt(32'h500, 1);  // R8 R9: dropped address has no episode
    idle(3, 1);
    expectEp(32'h200, 3, "R8");
    attempt(32'h200, 1);
    attempt(32'h500, 0);  // freed slot is reused
    check(ovfCount == modelOvf, "R8", "ovfCount after reuse", ovfCount, modelOvf);
    idle(2, 1);
    expectEp(32'h100, 5, "R8");
    attempt(32'h100, 1);
    expectEp(32'h500, 2, "R1");
    attempt(32'h500, 1);
    expectEp(32'h300, 5, "R3");
    attempt(32'h300, 1);
    expectEp(32'h400, 5, "R3");
    attempt(32'h400, 1);

    // R5: exactly at the threshold is a spin
    attempt(32'h600, 0);
    idle(WAIT_LIMIT, 1);
    expectEp(32'h600, WAIT_LIMIT, "R5");
    attempt(32'h600, 1);
    check(spinTotal == modelSpin, "R6", "spinTotal after threshold spin", spinTotal, modelSpin);

    // R5 R6 R7: one past the threshold is a wait
    attempt(32'h700, 0);
    idle(WAIT_LIMIT + 1, 1);
    expectEp(32'h700, WAIT_LIMIT + 1, "R5");
    attempt(32'h700, 1);
    check(spinTotal == modelSpin, "R6", "spinTotal unchanged by wait", spinTotal, modelSpin);
    check(waitCount == modelWait, "R7", "waitCount after wait", waitCount, modelWait);

    // R5: long wait saturates its length
    attempt(32'h800, 0);
    idle(6000, 1);
    expectEp(32'h800, 6000, "R5");
    attempt(32'h800, 1);
    check(waitCount == modelWait, "R7", "waitCount after second wait", waitCount, modelWait);
    check(spinTotal == modelSpin, "R6", "spinTotal final", spinTotal, modelSpin);

    idle(3, 0);
    check(expQ.size() == 0, "R3", "reports outstanding", expQ.size(), 0);
    check(ovfCount == modelOvf, "R8", "ovfCount final", ovfCount, modelOvf);
    finished = 1;
    summary();
  end
endmodule